// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller for a single successive-approximation conversion. A start pulse captures a command made of three fields: a channel number, a 2-bit sample-time code and an amplifier-bypass flag. The captured channel is decoded into a one-hot select for eight analog inputs, and that select is held for the whole conversion. The conversion then runs up to three phases, each counted in conversion-clock ticks. The first is an optional initial buffered-sample phase. The second is a final sample phase whose length comes from the code. The third is a resolution phase of fixed length, during which a 10-bit trial register is driven towards a comparator and refined one bit per tick.

The phases advance only on cycles where the conversion-clock enable is high, so the system clock can run faster than the conversion clock. Every command carries its own bypass flag. When the flag is set, the initial phase is skipped and that conversion is two ticks shorter. When the last bit has been resolved, the sequencer raises a one-cycle completion pulse, presents the result and returns to idle.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is high and on the cycle after it, the sequencer is idle: `busy`, `done`, all three phase strobes and every bit of `ch_sel` are 0.
- R2: A start pulse is taken only while `busy` is 0. A start pulse while `busy` is 1 changes neither the channel, the phase lengths nor the result of the conversion in progress.
- R3: While `busy` is 1, `ch_sel` has exactly one bit set, bit n for captured channel n, and it does not change until the conversion ends. While idle, `ch_sel` is all zeros.
- R4: Sample code 00 gives a final sample phase of 2 ticks, 01 gives 4, 10 gives 8 and 11 gives 16. The phase is marked by `ph_final`.
- R5: With the bypass flag at 0, an initial phase of exactly 2 ticks (`ph_init`) runs before the final sample phase. With the flag at 1, `ph_init` never rises and the conversion is 2 ticks shorter.
- R6: The resolution phase (`ph_resolve`) lasts exactly 10 ticks and resolves bit 9 first and bit 0 last. On each tick the current trial bit is kept when `cmp_ge` is 1 (input greater than or equal to `sar_val`) and cleared otherwise, so against an ideal comparator the result equals the input code.
- R7: On completion `done` is high for exactly one clock cycle with `result` valid, and `busy` is already 0 in that cycle.
- R8: On cycles where `tick` is 0, no phase counter, phase strobe or `sar_val` bit changes. A conversion is `2*(1-bypass) + (2<<code) + 10` ticks long, whatever the spacing of those ticks.
- R9: While busy, exactly one of `ph_init`, `ph_final` and `ph_resolve` is high. While idle, none is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Conversion-clock enable, one system cycle per tick |
| start | input | 1 | Start request, taken only when idle |
| cmd_chan | input | 3 | Channel number to convert |
| cmd_code | input | 2 | Final sample length code |
| cmd_bypass | input | 1 | Skip the initial buffered-sample phase |
| cmp_ge | input | 1 | Comparator: selected input >= sar_val |
| ch_sel | output | 8 | One-hot analog input select |
| ph_init | output | 1 | Initial buffered-sample phase strobe |
| ph_final | output | 1 | Final sample phase strobe |
| ph_resolve | output | 1 | Resolution phase strobe |
| sar_val | output | 10 | Current trial value toward the comparator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Converted code, valid with done |

## Verification
The bench builds the block with its default parameters: eight channels, a 10-bit resolution, a 2-bit sample code and a 2-tick initial phase. With these values all four sample lengths and both bypass settings can be run against every channel, and the longest conversion is only 28 ticks. Because the converted range is just 1024 codes, the end points 0 and 1023 and the mid-scale pair 511/512 can be hit directly alongside random inputs. The bench counts the ticks spent under each phase strobe, using both dense and sparse tick patterns, and compares the counts with the lengths set by the code and the bypass flag. Its ideal comparator makes each result equal to the input code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_INIT    = 2'd1,
        PH_FINAL   = 2'd2,
        PH_RESOLVE = 2'd3
    } phase_e;
endpackage

// File: rtl/adc_samp_len.sv
module adc_samp_len #(
    parameter int CODE_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  last_cnt
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] len;

    // final sample length is 2 << code; counter stops at length - 1
    always_comb begin
        len      = LEN_W'(2) << code;
        last_cnt = CNT_W'(len - LEN_W'(1));
    end
endmodule

// File: rtl/adc_chan_dec.sv
module adc_chan_dec #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              en,
    input  logic [CH_W-1:0]   chan,
    output logic [NUM_CH-1:0] sel
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel[i] = en && (chan == CH_W'(i));
    end
endmodule

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
    parameter int RES_BITS = 10
) (
    input  logic [RES_BITS-1:0] trial,
    input  logic [RES_BITS-1:0] mask,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] kept,
    output logic [RES_BITS-1:0] next_mask,
    output logic [RES_BITS-1:0] next_trial
);
    // the bit under test survives only if the input is at or above the trial
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        assign kept[i] = mask[i] ? cmp_ge : trial[i];
    end

    assign next_mask  = mask >> 1;
    assign next_trial = kept | next_mask;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 10,
    parameter int CODE_W   = 2,
    parameter int INIT_CYC = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        start,
    input  logic [$clog2(NUM_CH)-1:0]   cmd_chan,
    input  logic [CODE_W-1:0]           cmd_code,
    input  logic                        cmd_bypass,
    input  logic                        cmp_ge,
    output logic [NUM_CH-1:0]           ch_sel,
    output logic                        ph_init,
    output logic                        ph_final,
    output logic                        ph_resolve,
    output logic [RES_BITS-1:0]         sar_val,
    output logic                        busy,
    output logic                        done,
    output logic [RES_BITS-1:0]         result
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int MAX_LEN  = 2 << ((1 << CODE_W) - 1);
    localparam int LEN_CW   = $clog2(MAX_LEN);
    localparam int INIT_CW  = $clog2(INIT_CYC) + 1;
    localparam int CNT_W    = (LEN_CW > INIT_CW) ? LEN_CW : INIT_CW;
    localparam logic [CNT_W-1:0]    INIT_LAST = CNT_W'(INIT_CYC - 1);
    localparam logic [RES_BITS-1:0] TOP_BIT   = RES_BITS'(1) << (RES_BITS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CH_W-1:0]     chan;
        logic [CNT_W-1:0]    last;
        logic [CNT_W-1:0]    cnt;
        logic [RES_BITS-1:0] trial;
        logic [RES_BITS-1:0] mask;
        logic                done;
        logic [RES_BITS-1:0] result;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase:  PH_IDLE,
        chan:   '0,
        last:   '0,
        cnt:    '0,
        trial:  '0,
        mask:   '0,
        done:   1'b0,
        result: '0
    };

    seq_t st_d, st_q;

    logic [CNT_W-1:0]    cmd_last;
    logic [RES_BITS-1:0] step_kept;
    logic [RES_BITS-1:0] step_mask;
    logic [RES_BITS-1:0] step_trial;

    adc_samp_len #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_len (
        .code     (cmd_code),
        .last_cnt (cmd_last)
    );

    adc_chan_dec #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_dec (
        .en   (st_q.phase != PH_IDLE),
        .chan (st_q.chan),
        .sel  (ch_sel)
    );

    adc_sar_step #(
        .RES_BITS (RES_BITS)
    ) u_step (
        .trial      (st_q.trial),
        .mask       (st_q.mask),
        .cmp_ge     (cmp_ge),
        .kept       (step_kept),
        .next_mask  (step_mask),
        .next_trial (step_trial)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.chan  = cmd_chan;
                    st_d.last  = cmd_last;
                    st_d.cnt   = '0;
                    st_d.phase = cmd_bypass ? PH_FINAL : PH_INIT;
                end
            end
            PH_INIT: begin
                if (tick) begin
                    if (st_q.cnt == INIT_LAST) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_FINAL;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_FINAL: begin
                if (tick) begin
                    if (st_q.cnt == st_q.last) begin
                        st_d.cnt   = '0;
                        st_d.trial = TOP_BIT;
                        st_d.mask  = TOP_BIT;
                        st_d.phase = PH_RESOLVE;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_RESOLVE: begin
                if (tick) begin
                    if (st_q.mask[0]) begin
                        st_d.result = step_kept;
                        st_d.done   = 1'b1;
                        st_d.trial  = '0;
                        st_d.mask   = '0;
                        st_d.phase  = PH_IDLE;
                    end else begin
                        st_d.trial = step_trial;
                        st_d.mask  = step_mask;
                    end
                end
            end
            default: st_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_init    = (st_q.phase == PH_INIT);
    assign ph_final   = (st_q.phase == PH_FINAL);
    assign ph_resolve = (st_q.phase == PH_RESOLVE);
    assign busy       = (st_q.phase != PH_IDLE);
    assign sar_val    = st_q.trial;
    assign done       = st_q.done;
    assign result     = st_q.result;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                start,
    input logic [NUM_CH-1:0]   ch_sel,
    input logic                ph_init,
    input logic                ph_final,
    input logic                ph_resolve,
    input logic [RES_BITS-1:0] sar_val,
    input logic                busy,
    input logic                done
);
    // R3
    chsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(ch_sel) == 1));

    // R3
    chsel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ch_sel == '0));

    // R3
    chsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ch_sel));

    // R9
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_init, ph_final, ph_resolve}) == (busy ? 1 : 0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(sar_val) && $stable({ph_init, ph_final, ph_resolve})));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick) |=> busy);

    // R5
    init_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_init) |-> $past(!busy));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
    .NUM_CH   (NUM_CH),
    .RES_BITS (RES_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .start      (start),
    .ch_sel     (ch_sel),
    .ph_init    (ph_init),
    .ph_final   (ph_final),
    .ph_resolve (ph_resolve),
    .sar_val    (sar_val),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cmd_chan = '0;
    logic [1:0] cmd_code = '0;
    logic       cmd_bypass = 1'b0;
    logic       cmp_ge;
    logic [7:0] ch_sel;
    logic       ph_init, ph_final, ph_resolve;
    logic [9:0] sar_val;
    logic       busy, done;
    logic [9:0] result;

    logic [9:0] vin [8];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    adc_conv_seq i_adc_conv_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start      (start),
        .cmd_chan   (cmd_chan),
        .cmd_code   (cmd_code),
        .cmd_bypass (cmd_bypass),
        .cmp_ge     (cmp_ge),
        .ch_sel     (ch_sel),
        .ph_init    (ph_init),
        .ph_final   (ph_final),
        .ph_resolve (ph_resolve),
        .sar_val    (sar_val),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    // ideal comparator on whichever input the select routes through
    always_comb begin
        cmp_ge = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (ch_sel[i]) cmp_ge = (vin[i] >= sar_val);
        end
    end

    function automatic int exp_final(input logic [1:0] code);
        return 2 << code;
    endfunction

    function automatic int exp_init(input logic byp);
        return byp ? 0 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        finish_run();
    end

    // one conversion; pct = tick density, hold = idle-tick cycles checked for R8
    task automatic run_conv(input logic [2:0] ch, input logic [1:0] code, input logic byp,
                            input int pct, input bit inject, input int hold);
        int n_init = 0, n_fin = 0, n_res = 0, iter = 0;
        logic [7:0] sel0;
        logic [9:0] sv;
        logic [2:0] ph0;
        @(negedge clk);
        cmd_chan = ch; cmd_code = code; cmd_bypass = byp; start = 1'b1; tick = 1'b0;
        @(negedge clk);
        start = 1'b0;
        cmd_chan = ~ch; cmd_code = ~code; cmd_bypass = ~byp;
        chk(busy == 1'b1, "R2 start taken", busy, 1);
        chk(ch_sel == (8'd1 << ch), "R3 select", ch_sel, 8'd1 << ch);
        sel0 = ch_sel;
        // R8: without ticks nothing moves
        for (int h = 0; h < hold; h++) begin
            sv = sar_val; ph0 = {ph_init, ph_final, ph_resolve};
            tick = 1'b0;
            @(negedge clk);
            if (h == hold - 1)
                chk(sar_val == sv && {ph_init, ph_final, ph_resolve} == ph0 && busy,
                    "R8 hold", {ph_init, ph_final, ph_resolve}, ph0);
        end
        while (!done && iter < 2000) begin
            if (ch_sel != sel0) chk(1'b0, "R3 select stable", ch_sel, sel0);
            tick = (($urandom % 100) < pct);
            start = inject && (iter == 3);
            if (ph_init && tick) n_init++;
            if (ph_final && tick) n_fin++;
            if (ph_resolve && tick) n_res++;
            iter++;
            @(negedge clk);
        end
        tick = 1'b0;
        start = 1'b0;
        chk(done == 1'b1, "R7 done seen", done, 1);
        chk(busy == 1'b0, "R7 idle with done", busy, 0);
        chk(result == vin[ch], "R6 result", result, vin[ch]);
        chk(n_init == exp_init(byp), "R5 init ticks", n_init, exp_init(byp));
        chk(n_fin == exp_final(code), "R4 final ticks", n_fin, exp_final(code));
        chk(n_res == 10, "R6 resolve ticks", n_res, 10);
        chk(n_init + n_fin + n_res == exp_init(byp) + exp_final(code) + 10,
            inject ? "R2 ignored start" : "R8 length", n_init + n_fin + n_res,
            exp_init(byp) + exp_final(code) + 10);
        @(negedge clk);
        chk(done == 1'b0, "R7 one-cycle done", done, 0);
        chk(ch_sel == 8'd0, "R3 idle select", ch_sel, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a0c));
        for (int i = 0; i < 8; i++) vin[i] = 10'(i * 129);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && ch_sel == 0 && !ph_init && !ph_final && !ph_resolve,
            "R1 in reset", {busy, done, ph_init, ph_final, ph_resolve}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && ch_sel == 0, "R1 after reset", {busy, ch_sel}, 0);

        // directed corners: every code, both bypass settings, end-point inputs
        vin[0] = 10'd0; vin[7] = 10'd1023; vin[3] = 10'd512; vin[4] = 10'd511;
        for (int c = 0; c < 4; c++) begin
            run_conv(3'd0, 2'(c), 1'b0, 100, 1'b0, 0);
            run_conv(3'd7, 2'(c), 1'b1, 100, 1'b0, 0);
        end
        run_conv(3'd3, 2'd1, 1'b0, 100, 1'b0, 5);
        run_conv(3'd4, 2'd3, 1'b1, 40, 1'b1, 12);

        // reset in mid conversion (R1)
        @(negedge clk);
        cmd_chan = 3'd5; cmd_code = 2'd3; cmd_bypass = 1'b0; start = 1'b1; tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1; tick = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && ch_sel == 0 && !done, "R1 mid reset", {busy, ch_sel}, 0);

        // random mix
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 8; i++) vin[i] = 10'($urandom);
            run_conv(3'($urandom), 2'($urandom), 1'($urandom),
                     20 + int'($urandom % 81), 1'($urandom), int'($urandom % 4));
        end
        finish_run();
    end
endmodule